// File: doc/BRIEF.md
# Trace Buffer Register File

This block is the software-facing register file of a trace capture unit that stores trace words in a dedicated on-chip SRAM. A debug agent uses a simple 32-bit register bus to power the unit up, configure the circular buffer, start and stop capture, and then drain the captured words one at a time through a data window. Each read of the window returns the SRAM word under the read pointer and moves that pointer forward. The pointer wraps from the buffer's upper bound back to its base.

The block also owns the write pointer for an external writer. The writer stores a word at the address `wp_addr` and pulses `wr_push`. The block then steps the pointer, wraps it at the bound, records a wrap flag and, if asked, stops capture on wrap. The register bus has no back-pressure: every access completes in the cycle it is presented, and a read answers on the next cycle with `reg_rvalid`. `wr_push` is always accepted.

Addresses are byte offsets: control 0x00, identity 0x04, base 0x10, base-high 0x14, bound 0x18, bound-high 0x1C, write pointer 0x20, write-pointer-high 0x24, read pointer 0x28, read-pointer-high 0x2C, data window 0x40. The control fields are: bit 0 power request/status, bit 1 capture enable, bit 3 drained (read-only), bit 4 mode, bit 8 halt-on-wrap, bits 10:9 layout, bits 14:12 sync spacing.

Top module: `trs_sink_regs`

## Requirements
- R1: After reset, every register reads 0, including bit 0 of control.
- R2: Bit 0 of control reads the written power request only `ACT_DELAY` cycles after the write. While it reads 0, all other registers read 0 and ignore writes. Powering down restores the reset values: bound at maximum, pointers 0, enable and halt-on-wrap cleared.
- R3: The identity register reads 0x0000_1901: major 1 in bits 3:0, minor 0 in bits 7:4, type 0x9 in bits 11:8, SRAM support in bit 12 set, system-memory support in bit 13 clear.
- R4: Control bits 1 and 8 hold written values. Bit 3 reflects `wr_empty`. Bits 4, 10:9 and 14:12 and all reserved bits always read 0.
- R5: The base register and all high registers read 0, and writes to them are ignored.
- R6: The bound resets to (2^MEM_AW-1)*4. A write stores the word index of the value. A value beyond the top word, including all ones, gives the maximum, and zero gives 0.
- R7: A data-window read returns the SRAM word at the read pointer. The pointer then moves on by 4 bytes, and a read at the bound reloads it to 0.
- R8: Each `wr_push` advances the write pointer by 4 bytes, and from the bound it returns to 0 and sets write-pointer bit 0 (wrap flag). Bit 1 reads 0, and a write to the write pointer clears the flag.
- R9: With halt-on-wrap set, a push at the bound clears capture enable.
- R10: While capture is busy (enable set or `wr_empty` low), writes to the bound, write pointer and read pointer are ignored, and data-window reads do not move the read pointer.
- R11: `reg_rvalid` is high exactly on the cycle after each `reg_rd`, carrying the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| sram_rd_en | output | 1 | SRAM read enable |
| sram_rd_addr | output | MEM_AW | SRAM word address, the read pointer |
| sram_rd_data | input | 32 | SRAM read data, one cycle after enable |
| wr_push | input | 1 | Writer stored a word at wp_addr |
| wr_empty | input | 1 | Writer holds no buffered trace |
| wp_addr | output | MEM_AW | Word index for the next writer store |
| ctl_enable | output | 1 | Capture enable to the writer |
| ctl_stop_on_wrap | output | 1 | Halt-on-wrap setting to the writer |
| cfg_limit | output | MEM_AW | Buffer bound as a word index |

## Verification
The assertions check on every cycle the read handshake timing, that the read pointer holds still whenever capture is busy, that the wrap flag rises only after a push, that a halting wrap drops enable, and that enable and the flag stay clear while powered down. The bench scenarios cover the rest: the power-up delay as seen at the bus, field masking, bound clamping, the order of words drained through the window across a wrap, refusal of writes while busy, and the return to reset values after power-down.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam logic [7:0] OFF_CTRL     = 8'h00;
  localparam logic [7:0] OFF_IMPL     = 8'h04;
  localparam logic [7:0] OFF_BASE_LO  = 8'h10;
  localparam logic [7:0] OFF_BASE_HI  = 8'h14;
  localparam logic [7:0] OFF_LIMIT_LO = 8'h18;
  localparam logic [7:0] OFF_LIMIT_HI = 8'h1C;
  localparam logic [7:0] OFF_WP_LO    = 8'h20;
  localparam logic [7:0] OFF_WP_HI    = 8'h24;
  localparam logic [7:0] OFF_RP_LO    = 8'h28;
  localparam logic [7:0] OFF_RP_HI    = 8'h2C;
  localparam logic [7:0] OFF_DATA     = 8'h40;

  localparam int CTL_ACTIVE = 0;
  localparam int CTL_ENABLE = 1;
  localparam int CTL_EMPTY  = 3;
  localparam int CTL_HALT   = 8;
  localparam int WP_WRAP    = 0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_IMPL, SEL_LIMIT, SEL_WP, SEL_RP, SEL_DATA
  } reg_sel_e;

  function automatic logic [31:0] impl_word(input logic has_sram, input logic has_smem);
    return {18'd0, has_smem, has_sram, 4'h9, 4'h0, 4'h1};
  endfunction
endpackage

// File: rtl/trs_power_seq.sv
module trs_power_seq #(
  parameter int ACT_DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack
);
  localparam int CNT_W = $clog2(ACT_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACT_DELAY - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      cnt_q <= '0;
    end else if (req != ack) begin
      if (cnt_q == CNT_LAST) begin
        ack   <= req;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/trs_wrap_ptr.sv
module trs_wrap_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (clear) ptr <= '0;
    else if (load)  ptr <= load_val;
    else if (step)  ptr <= (ptr == limit) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/trs_sink_regs.sv
module trs_sink_regs
  import trs_pkg::*;
#(
  parameter int MEM_AW          = 10,
  parameter int ADDR_W          = 8,
  parameter int ACT_DELAY       = 8,
  parameter bit RD_WHILE_ACTIVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              sram_rd_en,
  output logic [MEM_AW-1:0] sram_rd_addr,
  input  logic [31:0]       sram_rd_data,
  input  logic              wr_push,
  input  logic              wr_empty,
  output logic [MEM_AW-1:0] wp_addr,
  output logic              ctl_enable,
  output logic              ctl_stop_on_wrap,
  output logic [MEM_AW-1:0] cfg_limit
);
  localparam int PAD_W = 30 - MEM_AW;
  localparam logic [MEM_AW-1:0] LIMIT_MAX = '1;

  function automatic logic [MEM_AW-1:0] to_word(input logic [31:0] v);
    logic [29:0] w;
    w = v[31:2];
    if ((w >> MEM_AW) != 30'd0) return LIMIT_MAX;
    return w[MEM_AW-1:0];
  endfunction

  function automatic logic [31:0] to_byte(input logic [MEM_AW-1:0] p);
    return {{PAD_W{1'b0}}, p, 2'b00};
  endfunction

  reg_sel_e          sel;
  logic              act_req, act_ack;
  logic              enable_q, halt_q, wrap_q;
  logic [MEM_AW-1:0] limit_q, wp_ptr, rp_ptr;
  logic              trace_busy, rp_open;
  logic              wr_ctl, wp_load, wp_step, wp_wrap, rp_load, rp_step;
  logic [31:0]       rd_word, rdata_q;
  logic              rvalid_q, mem_sel_q;

  // address decode
  always_comb begin
    case (reg_addr)
      ADDR_W'(OFF_CTRL):     sel = SEL_CTRL;
      ADDR_W'(OFF_IMPL):     sel = SEL_IMPL;
      ADDR_W'(OFF_LIMIT_LO): sel = SEL_LIMIT;
      ADDR_W'(OFF_WP_LO):    sel = SEL_WP;
      ADDR_W'(OFF_RP_LO):    sel = SEL_RP;
      ADDR_W'(OFF_DATA):     sel = SEL_DATA;
      default:               sel = SEL_NONE;
    endcase
  end

  // power request and delayed status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         act_req <= 1'b0;
    else if (reg_wr && sel == SEL_CTRL) act_req <= reg_wdata[CTL_ACTIVE];
  end

  trs_power_seq #(.ACT_DELAY(ACT_DELAY)) u_pwr (
    .clk(clk), .rst_n(rst_n), .req(act_req), .ack(act_ack)
  );

  assign trace_busy = enable_q || !wr_empty;
  assign rp_open    = !trace_busy || RD_WHILE_ACTIVE;
  assign wr_ctl     = act_ack && reg_wr && sel == SEL_CTRL;
  assign wp_load    = act_ack && reg_wr && sel == SEL_WP && !trace_busy;
  assign wp_step    = act_ack && wr_push;
  assign wp_wrap    = wp_step && !wp_load && wp_ptr == limit_q;
  assign rp_load    = act_ack && reg_wr && sel == SEL_RP && rp_open;
  assign rp_step    = act_ack && reg_rd && sel == SEL_DATA && rp_open;

  // control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      halt_q   <= 1'b0;
    end else if (!act_ack) begin
      enable_q <= 1'b0;
      halt_q   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        enable_q <= reg_wdata[CTL_ENABLE];
        halt_q   <= reg_wdata[CTL_HALT];
      end
      if (wp_wrap && halt_q) enable_q <= 1'b0;
    end
  end

  // buffer bound
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= LIMIT_MAX;
    else if (!act_ack) limit_q <= LIMIT_MAX;
    else if (reg_wr && sel == SEL_LIMIT && !trace_busy)
      limit_q <= to_word(reg_wdata);
  end

  // wrap flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wrap_q <= 1'b0;
    else if (!act_ack) wrap_q <= 1'b0;
    else if (wp_load)  wrap_q <= 1'b0;
    else if (wp_wrap)  wrap_q <= 1'b1;
  end

  trs_wrap_ptr #(.AW(MEM_AW)) u_wp (
    .clk(clk), .rst_n(rst_n), .clear(!act_ack), .load(wp_load),
    .load_val(to_word(reg_wdata)), .step(wp_step), .limit(limit_q), .ptr(wp_ptr)
  );

  trs_wrap_ptr #(.AW(MEM_AW)) u_rp (
    .clk(clk), .rst_n(rst_n), .clear(!act_ack), .load(rp_load),
    .load_val(to_word(reg_wdata)), .step(rp_step), .limit(limit_q), .ptr(rp_ptr)
  );

  // read mux
  always_comb begin
    rd_word = '0;
    if (sel == SEL_CTRL) rd_word[CTL_ACTIVE] = act_ack;
    if (act_ack) begin
      case (sel)
        SEL_CTRL: begin
          rd_word[CTL_ENABLE] = enable_q;
          rd_word[CTL_EMPTY]  = wr_empty;
          rd_word[CTL_HALT]   = halt_q;
        end
        SEL_IMPL:  rd_word = impl_word(1'b1, 1'b0);
        SEL_LIMIT: rd_word = to_byte(limit_q);
        SEL_WP:    rd_word = to_byte(wp_ptr) | {31'd0, wrap_q};
        SEL_RP:    rd_word = to_byte(rp_ptr);
        default:   rd_word = '0;
      endcase
    end
  end

  assign sram_rd_en   = act_ack && reg_rd && sel == SEL_DATA;
  assign sram_rd_addr = rp_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q  <= 1'b0;
      mem_sel_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rvalid_q  <= reg_rd;
      mem_sel_q <= sram_rd_en;
      if (reg_rd) rdata_q <= rd_word;
    end
  end

  assign reg_rdata        = mem_sel_q ? sram_rd_data : rdata_q;
  assign reg_rvalid       = rvalid_q;
  assign wp_addr          = wp_ptr;
  assign ctl_enable       = enable_q;
  assign ctl_stop_on_wrap = halt_q;
  assign cfg_limit        = limit_q;
endmodule

// File: rtl/trs_sink_regs_chk.sv
module trs_sink_regs_chk #(
  parameter int MEM_AW          = 10,
  parameter bit RD_WHILE_ACTIVE = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_rvalid,
  input logic              act_ack,
  input logic              ctl_enable,
  input logic              ctl_stop_on_wrap,
  input logic              trace_busy,
  input logic              wrap_flag,
  input logic              wr_push,
  input logic              wp_load,
  input logic [MEM_AW-1:0] wp_ptr,
  input logic [MEM_AW-1:0] rp_ptr,
  input logic [MEM_AW-1:0] limit
);
  a_r11_rvalid_next: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  a_r10_rp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ack && trace_busy && !RD_WHILE_ACTIVE) |=> $stable(rp_ptr));

  a_r8_wrap_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_flag) |-> $past(wr_push));

  a_r9_halt_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ack && wr_push && !wp_load && ctl_stop_on_wrap && wp_ptr == limit) |=> !ctl_enable);

  a_r2_down_is_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_ack && $past(!act_ack)) |-> (!ctl_enable && !wrap_flag));
endmodule

bind trs_sink_regs trs_sink_regs_chk #(.MEM_AW(MEM_AW), .RD_WHILE_ACTIVE(RD_WHILE_ACTIVE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .act_ack(act_ack), .ctl_enable(ctl_enable), .ctl_stop_on_wrap(ctl_stop_on_wrap),
  .trace_busy(trace_busy), .wrap_flag(wrap_q), .wr_push(wr_push), .wp_load(wp_load),
  .wp_ptr(wp_ptr), .rp_ptr(rp_ptr), .limit(limit_q)
);

// File: tb/trs_sink_regs_tb.sv
`timescale 1ns/1ps
module trs_sink_regs_tb;
  localparam int MEM_AW = 4;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int ACT_DELAY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid, sram_rd_en;
  logic [MEM_AW-1:0] sram_rd_addr, wp_addr, cfg_limit;
  logic [31:0] sram_rd_data;
  logic        wr_push = 1'b0, wr_empty = 1'b1;
  logic        ctl_enable, ctl_stop_on_wrap;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mem [DEPTH];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  trs_sink_regs #(.MEM_AW(MEM_AW), .ADDR_W(8), .ACT_DELAY(ACT_DELAY)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .sram_rd_en(sram_rd_en), .sram_rd_addr(sram_rd_addr), .sram_rd_data(sram_rd_data),
    .wr_push(wr_push), .wr_empty(wr_empty), .wp_addr(wp_addr),
    .ctl_enable(ctl_enable), .ctl_stop_on_wrap(ctl_stop_on_wrap), .cfg_limit(cfg_limit)
  );

  // SRAM model, one-cycle read
  always @(posedge clk) if (sram_rd_en) sram_rd_data <= mem[sram_rd_addr];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: actual rvalid 1 expected 0");
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] d);
    @(negedge clk);
    mem[wp_addr] = d; wr_push = 1'b1;
    @(negedge clk);
    wr_push = 1'b0;
  endtask

  task automatic power(input logic [31:0] v);
    reg_write(8'h00, v);
    repeat (ACT_DELAY + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    reg_read(8'h00, 32'h0, "R1 ctrl");
    reg_read(8'h04, 32'h0, "R1 impl");
    reg_read(8'h18, 32'h0, "R1 limit");

    // R2: writes ignored while powered down, delayed status
    reg_write(8'h18, 32'h0);
    reg_write(8'h00, 32'h1);
    reg_read(8'h00, 32'h0, "R2 status lags");
    repeat (ACT_DELAY + 2) @(negedge clk);
    reg_read(8'h00, 32'h9, "R2 status up");
    reg_read(8'h18, 32'h3C, "R2 write while down ignored");

    // R3
    reg_read(8'h04, 32'h0000_1901, "R3 identity");

    // R4: field masking
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, 32'h0000_010B, "R4 fields");
    reg_write(8'h00, 32'h1);
    reg_read(8'h00, 32'h9, "R4 cleared");

    // R5: base and high registers
    reg_write(8'h10, 32'hFFFF_FFFF);
    reg_read(8'h10, 32'h0, "R5 base");
    reg_write(8'h14, 32'hFFFF_FFFF);
    reg_read(8'h14, 32'h0, "R5 base high");
    reg_write(8'h1C, 32'hFFFF_FFFF);
    reg_read(8'h1C, 32'h0, "R5 bound high");
    reg_write(8'h24, 32'hFFFF_FFFF);
    reg_read(8'h24, 32'h0, "R5 wp high");
    reg_write(8'h2C, 32'hFFFF_FFFF);
    reg_read(8'h2C, 32'h0, "R5 rp high");

    // R6: bound limits
    reg_write(8'h18, 32'h0);
    reg_read(8'h18, 32'h0, "R6 lowest");
    reg_write(8'h18, 32'hFFFF_FFFF);
    reg_read(8'h18, 32'h3C, "R6 highest");
    reg_write(8'h18, 32'h0000_0400);
    reg_read(8'h18, 32'h3C, "R6 clamp");
    reg_write(8'h18, 32'h1C);
    reg_read(8'h18, 32'h1C, "R6 trim");

    // R8: capture ten words into an eight-word buffer
    reg_write(8'h20, 32'h0);
    reg_write(8'h28, 32'h0);
    reg_write(8'h00, 32'h3);
    for (int i = 0; i < 10; i++) push_word(32'hA500_0000 + i);
    reg_read(8'h20, 32'h9, "R8 wp wrapped with flag");

    // R10: writes refused, reads do not advance while busy
    reg_write(8'h28, 32'h10);
    reg_read(8'h28, 32'h0, "R10 rp write ignored");
    reg_write(8'h18, 32'h0);
    reg_read(8'h18, 32'h1C, "R10 bound write ignored");
    reg_write(8'h20, 32'h0);
    reg_read(8'h20, 32'h9, "R10 wp write ignored");
    reg_read(8'h40, 32'hA500_0008, "R10 data read while busy");
    reg_read(8'h28, 32'h0, "R10 rp held");

    // R4: drained flag follows writer
    wr_empty = 1'b0;
    reg_write(8'h00, 32'h1);
    reg_read(8'h00, 32'h1, "R4 not drained");
    reg_write(8'h28, 32'h8);
    reg_read(8'h28, 32'h0, "R10 busy while draining");
    wr_empty = 1'b1;
    reg_read(8'h00, 32'h9, "R4 drained");

    // R7: drain in order across the bound
    reg_read(8'h40, 32'hA500_0008, "R7 word0");
    reg_read(8'h40, 32'hA500_0009, "R7 word1");
    for (int i = 2; i < 8; i++) reg_read(8'h40, 32'hA500_0000 + i, "R7 word");
    reg_read(8'h28, 32'h0, "R7 rp back to base");
    reg_read(8'h40, 32'hA500_0008, "R7 after wrap");
    reg_read(8'h28, 32'h4, "R7 rp step");

    // R8: flag clear and low bits
    reg_write(8'h20, 32'h0);
    reg_read(8'h20, 32'h0, "R8 flag cleared");
    reg_write(8'h20, 32'hFFFF_FFFF);
    reg_read(8'h20, 32'h3C, "R8 low bits zero");
    reg_write(8'h20, 32'h0);

    // R9: halt on wrap
    reg_write(8'h00, 32'h103);
    for (int i = 0; i < 8; i++) push_word(32'hE700_0000 + i);
    reg_read(8'h00, 32'h109, "R9 enable dropped");
    reg_read(8'h20, 32'h1, "R9 wp at base with flag");
    reg_read(8'h40, 32'hE700_0001, "R7 read after halt");

    // R2: power down and back up
    power(32'h0);
    reg_read(8'h00, 32'h0, "R2 status down");
    reg_read(8'h18, 32'h0, "R2 bound hidden");
    reg_read(8'h04, 32'h0, "R2 identity hidden");
    power(32'h1);
    reg_read(8'h18, 32'h3C, "R2 bound restored");
    reg_read(8'h28, 32'h0, "R2 rp restored");
    reg_read(8'h00, 32'h9, "R2 control restored");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11: actual %0d missing reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule